// File: doc/BRIEF.md
# Shift-Chain Length Discovery Unit

This unit works out, at start-up, the length of a serial shift-register chain whose length is not known in advance. The chain hangs off four lines: a serial data line into the chain, a serial data line back from its far end, a shift clock that idles high, and a strobe that makes the input stages capture their parallel pins. The chain is made of output stages on the near side followed by input stages on the far side. A fifth line is an output latch strobe, which stays high for the whole time.

A one-cycle `start` pulse runs the discovery. First a flush pass clocks zeros through the chain. A sizing pass then drives ones and counts the shifts until the first one comes back, which gives the total stage count. Last, ten strobed search passes run, one zeros pass and one ones pass in each of five rounds. Each search pass drives a level and records the last sample that matched it. The largest of these results is the number of input stages, and the remaining stages are outputs.

All line timing is set in units of microseconds through `CLKS_PER_US`. Each phase lasts four microseconds.

Top module: `shchain_probe`

## Requirements
- R1: While reset is held and until the first start, `shift_clk` is 1, `in_load` is 0, `out_latch` is 1, `ser_out` is 0, and `done`, `error` and all three counts are 0.
- R2: Every low phase of `shift_clk` lasts exactly PH = 4*CLKS_PER_US cycles. A run issues 64 clock pulses plus 10*total more when sizing succeeds, and exactly 64 when it fails.
- R3: A run whose sizing succeeds gives exactly ten `in_load` pulses, each high for exactly PH cycles, with `shift_clk` high throughout. A failed run gives none.
- R4: For a chain of 1 to 31 stages, `total_cnt` equals the number of stages. The chain's starting contents do not affect the result.
- R5: If no one arrives at `ser_in` within 32 shifts, `error` is set together with `done`, all counts are 0, and no search pass runs. A 32-stage chain is one such case.
- R6: `in_cnt` equals the number of input stages, whatever value is on the parallel pin captured into the input stage next to the outputs. The bench calls this pin bit 0.
- R7: At `done`, `out_cnt` equals `total_cnt - in_cnt`.
- R8: `start` clears `done` on the next cycle. The counts stay fixed while `done` is high. A `start` that arrives during a run is ignored.
- R9: If `ser_in` is held at 1 (no chain present), the result is total 0, inputs 0, outputs 0, with no error.
- R10: `ser_out` does not change while `shift_clk` is low, and it has been stable for at least PH cycles at each falling edge of `shift_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins discovery |
| ser_in | input | 1 | Data from the far end of the chain (asynchronous) |
| ser_out | output | 1 | Data driven into the near end of the chain |
| shift_clk | output | 1 | Chain shift clock, idles high |
| in_load | output | 1 | Input-stage capture strobe, captures on its falling edge |
| out_latch | output | 1 | Output latch strobe, held high |
| done | output | 1 | Counts are valid |
| error | output | 1 | Sizing found no end of the chain within 32 shifts |
| total_cnt | output | 6 | Total stage count |
| in_cnt | output | 6 | Input stage count |
| out_cnt | output | 6 | Output stage count |

## Verification
The properties assume that `start` is a single-cycle pulse and that CLKS_PER_US is large enough for PH to be at least 3. They also assume the chain moves its last stage onto `ser_in` well within one phase after a rising edge of `shift_clk`, so the two-flop synchronizer has settled before each sample. The bench chain model reacts half a clock cycle after each rising edge and after each falling edge of the strobe, and it holds the parallel pins steady for a whole run. Chain lengths and pin values are drawn at random within 1 to 31 stages. Directed runs add the 32-stage overflow, a line stuck high, a line stuck low, and both values of the boundary pin.

// File: rtl/shchain_pkg.sv
package shchain_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_STROBE,
    PS_SETTLE,
    PS_LOW,
    PS_HIGH
  } pass_st_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FLUSH,
    SQ_SIZE,
    SQ_SEARCH
  } seq_st_t;

endpackage

// File: rtl/shchain_timer.sv
module shchain_timer #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned TW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/shchain_pass.sv
module shchain_pass
  import shchain_pkg::*;
#(
  parameter int unsigned PHASE = 4,
  parameter int unsigned CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          last_mode,
  input  logic          level,
  input  logic [CW-1:0] num,
  input  logic          sin_sync,
  output logic          ser_out,
  output logic          shift_clk,
  output logic          in_load,
  output logic          pass_done,
  output logic [CW-1:0] result,
  output logic          sample_evt
);
  pass_st_t      st;
  logic          lvl, keep_last, expired, restart, hit;
  logic [CW-1:0] nlim, idx;

  // first-match keeps the earliest hit, last-match overwrites with every hit
  function automatic logic [CW-1:0] next_res(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] pos,
                                             input logic          is_hit,
                                             input logic          last);
    if (is_hit && (last || cur == '0)) return pos;
    return cur;
  endfunction

  assign sample_evt = expired && (st == PS_SETTLE || st == PS_HIGH) && (idx != nlim);
  assign hit        = (sin_sync == lvl);
  assign restart    = (st == PS_IDLE) ? go : expired;

  shchain_timer #(.TICKS(PHASE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_IDLE;
      lvl       <= 1'b0;
      keep_last <= 1'b0;
      nlim      <= '0;
      idx       <= '0;
      result    <= '0;
      ser_out   <= 1'b0;
      shift_clk <= 1'b1;
      in_load   <= 1'b0;
      pass_done <= 1'b0;
    end else begin
      pass_done <= 1'b0;
      unique case (st)
        PS_IDLE: if (go) begin
          lvl       <= level;
          keep_last <= last_mode;
          nlim      <= num;
          idx       <= '0;
          result    <= '0;
          ser_out   <= level;
          in_load   <= last_mode;
          st        <= last_mode ? PS_STROBE : PS_SETTLE;
        end
        PS_STROBE: if (expired) begin
          in_load <= 1'b0;
          st      <= PS_SETTLE;
        end
        PS_SETTLE, PS_HIGH: if (expired) begin
          if (sample_evt) begin
            shift_clk <= 1'b0;
            idx       <= idx + 1'b1;
            result    <= next_res(result, idx + 1'b1, hit, keep_last);
            st        <= PS_LOW;
          end else begin
            pass_done <= 1'b1;
            st        <= PS_IDLE;
          end
        end
        PS_LOW: if (expired) begin
          shift_clk <= 1'b1;
          st        <= PS_HIGH;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shchain_probe.sv
module shchain_probe
  import shchain_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned PHASE_US    = 4,
  parameter int unsigned MAX_STAGES  = 32,
  parameter int unsigned ROUNDS      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       shift_clk,
  output logic       in_load,
  output logic       out_latch,
  output logic       done,
  output logic       error,
  output logic [5:0] total_cnt,
  output logic [5:0] in_cnt,
  output logic [5:0] out_cnt
);
  localparam int unsigned PHASE = PHASE_US * CLKS_PER_US;
  localparam int unsigned CW    = $clog2(MAX_STAGES + 1);
  localparam int unsigned RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  seq_st_t       sq;
  logic          s1, s2;
  logic          pass_go, go_last, go_lvl, pass_done, sample_evt;
  logic [CW-1:0] go_num, pass_res, best, best_n, tot;
  logic [RW-1:0] round;

  function automatic logic [CW-1:0] keep_max(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (b > a) ? b : a;
  endfunction

  function automatic logic [CW-1:0] split_rest(input logic [CW-1:0] all, input logic [CW-1:0] part);
    return all - part;
  endfunction

  assign out_latch = 1'b1;
  assign best_n    = keep_max(best, pass_res);

  // two-flop synchronizer, idles at the pulled-up level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= ser_in;
      s2 <= s1;
    end
  end

  shchain_pass #(.PHASE(PHASE), .CW(CW)) u_pass (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (pass_go),
    .last_mode  (go_last),
    .level      (go_lvl),
    .num        (go_num),
    .sin_sync   (s2),
    .ser_out    (ser_out),
    .shift_clk  (shift_clk),
    .in_load    (in_load),
    .pass_done  (pass_done),
    .result     (pass_res),
    .sample_evt (sample_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq        <= SQ_IDLE;
      pass_go   <= 1'b0;
      go_last   <= 1'b0;
      go_lvl    <= 1'b0;
      go_num    <= '0;
      round     <= '0;
      best      <= '0;
      tot       <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      total_cnt <= '0;
      in_cnt    <= '0;
      out_cnt   <= '0;
    end else begin
      pass_go <= 1'b0;
      unique case (sq)
        SQ_IDLE: if (start) begin
          done      <= 1'b0;
          error     <= 1'b0;
          total_cnt <= '0;
          in_cnt    <= '0;
          out_cnt   <= '0;
          best      <= '0;
          pass_go   <= 1'b1;
          go_last   <= 1'b0;
          go_lvl    <= 1'b0;
          go_num    <= CW'(MAX_STAGES);
          sq        <= SQ_FLUSH;
        end
        SQ_FLUSH: if (pass_done) begin
          pass_go <= 1'b1;
          go_last <= 1'b0;
          go_lvl  <= 1'b1;
          go_num  <= CW'(MAX_STAGES);
          sq      <= SQ_SIZE;
        end
        SQ_SIZE: if (pass_done) begin
          if (pass_res == '0) begin
            error <= 1'b1;
            done  <= 1'b1;
            sq    <= SQ_IDLE;
          end else begin
            tot       <= pass_res - 1'b1;
            total_cnt <= 6'(pass_res - 1'b1);
            round     <= '0;
            pass_go   <= 1'b1;
            go_last   <= 1'b1;
            go_lvl    <= 1'b0;
            go_num    <= pass_res - 1'b1;
            sq        <= SQ_SEARCH;
          end
        end
        SQ_SEARCH: if (pass_done) begin
          best <= best_n;
          if (!go_lvl) begin
            pass_go <= 1'b1;
            go_lvl  <= 1'b1;
          end else if (round == RW'(ROUNDS - 1)) begin
            in_cnt  <= 6'(best_n);
            out_cnt <= 6'(split_rest(tot, best_n));
            done    <= 1'b1;
            sq      <= SQ_IDLE;
          end else begin
            round   <= round + 1'b1;
            pass_go <= 1'b1;
            go_lvl  <= 1'b0;
          end
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shchain_probe_chk.sv
module shchain_probe_chk #(
  parameter int unsigned PHASE = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_out,
  input logic       shift_clk,
  input logic       in_load,
  input logic       done,
  input logic       error,
  input logic [5:0] total_cnt,
  input logic [5:0] in_cnt,
  input logic [5:0] out_cnt,
  input logic       pass_go
);
  logic [15:0] lo_len, ld_len, since_chg;
  logic        so_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len    <= '0;
      ld_len    <= '0;
      since_chg <= '0;
      so_q      <= 1'b0;
    end else begin
      so_q      <= ser_out;
      lo_len    <= shift_clk ? '0 : ((lo_len == '1) ? lo_len : lo_len + 1'b1);
      ld_len    <= !in_load ? '0 : ((ld_len == '1) ? ld_len : ld_len + 1'b1);
      since_chg <= (ser_out != so_q) ? '0 : ((since_chg == '1) ? since_chg : since_chg + 1'b1);
    end
  end

  // R2
  clk_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_clk) |-> lo_len == 16'(PHASE));

  // R2
  pass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_go |-> shift_clk && !in_load);

  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_load) |-> ld_len == 16'(PHASE));

  // R3
  strobe_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |-> shift_clk);

  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done && total_cnt == 6'd0 && in_cnt == 6'd0 && out_cnt == 6'd0);

  // R7
  split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (7'(out_cnt) + 7'(in_cnt)) == 7'(total_cnt));

  // R8
  hold_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> $stable(total_cnt) && $stable(in_cnt) && $stable(out_cnt));

  // R10
  sout_low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_clk |-> $stable(ser_out));

  // R10
  sout_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_clk) |-> since_chg >= 16'(PHASE - 1));
endmodule

bind shchain_probe shchain_probe_chk #(.PHASE(PHASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_out   (ser_out),
  .shift_clk (shift_clk),
  .in_load   (in_load),
  .done      (done),
  .error     (error),
  .total_cnt (total_cnt),
  .in_cnt    (in_cnt),
  .out_cnt   (out_cnt),
  .pass_go   (pass_go)
);

// File: tb/shchain_probe_test.sv
`timescale 1ns/1ps
module shchain_probe_test;
  localparam int CPU    = 1;
  localparam int PH     = 4 * CPU;
  localparam int MAXS   = 32;
  localparam int ROUNDS = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic ser_in, ser_out, shift_clk, in_load, out_latch, done, error;
  logic [5:0] total_cnt, in_cnt, out_cnt;

  shchain_probe #(.CLKS_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_in(ser_in),
    .ser_out(ser_out), .shift_clk(shift_clk), .in_load(in_load),
    .out_latch(out_latch), .done(done), .error(error),
    .total_cnt(total_cnt), .in_cnt(in_cnt), .out_cnt(out_cnt)
  );

  always #2.5 clk = ~clk;

  // chain model: position 0 is nearest ser_out, last stage drives ser_in
  logic [63:0] chain = '1;
  int n_out = 0, n_in = 0;
  logic [31:0] pins = '0;
  logic stuck_en = 1'b0, stuck_val = 1'b1;
  assign ser_in = stuck_en ? stuck_val :
                  ((n_out + n_in) == 0) ? ser_out : chain[n_out + n_in - 1];

  int falls = 0, loads = 0, bad_low = 0, bad_ld = 0, bad_settle = 0;
  int low_len = 0, ld_len = 0, since = 0, cyc_all = 0;
  logic prev_sck = 1'b1, prev_ld = 1'b0, prev_so = 1'b0;
  int total = 0, bad = 0;

  always @(negedge clk) begin
    if (ser_out !== prev_so) since = 0; else since++;
    if (prev_sck === 1'b0 && shift_clk === 1'b1) begin
      if (low_len != PH) bad_low++;
      chain = {chain[62:0], ser_out};
    end
    if (prev_sck === 1'b1 && shift_clk === 1'b0) begin
      falls++;
      if (since < PH) bad_settle++;
    end
    if (shift_clk === 1'b0 && ser_out !== prev_so) bad_settle++;
    if (prev_ld === 1'b1 && in_load === 1'b0) begin
      loads++;
      if (ld_len != PH) bad_ld++;
      for (int j = 0; j < n_in; j++) chain[n_out + j] = pins[j];
    end
    low_len  = (shift_clk === 1'b0) ? low_len + 1 : 0;
    ld_len   = (in_load === 1'b1) ? ld_len + 1 : 0;
    prev_sck = shift_clk;
    prev_ld  = in_load;
    prev_so  = ser_out;
  end

  always @(negedge clk) begin
    cyc_all++;
    if (cyc_all > 190000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 190000);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_err(int t, bit se, bit sv);
    if (se) return sv ? 0 : 1;
    return (t >= MAXS) ? 1 : 0;
  endfunction
  function automatic int exp_tot(int t, bit se, bit sv);
    if (exp_err(t, se, sv) != 0 || se) return 0;
    return t;
  endfunction
  function automatic int exp_in(int t, int ni, bit se, bit sv);
    if (exp_tot(t, se, sv) == 0) return 0;
    return ni;
  endfunction

  task automatic run(input int no, input int ni, input logic [31:0] pv,
                     input bit se, input bit sv, input bit poke);
    int p0, l0, cyc, t, tt, ti;
    t = no + ni;
    n_out = no; n_in = ni; pins = pv; stuck_en = se; stuck_val = sv;
    @(negedge clk);
    p0 = falls; l0 = loads;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    eq("R8 done clears after start", int'(done), 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 100);
    end
    start = 1'b0;
    tt = exp_tot(t, se, sv);
    ti = exp_in(t, ni, se, sv);
    eq("R5 error flag", int'(error), exp_err(t, se, sv));
    eq(se ? "R9 total" : "R4 total", int'(total_cnt), tt);
    eq("R6 inputs", int'(in_cnt), ti);
    eq("R7 outputs", int'(out_cnt), tt - ti);
    eq("R2 pulse count", falls - p0, 2 * MAXS + (exp_err(t, se, sv) != 0 ? 0 : 2 * ROUNDS * tt));
    eq("R3 strobe count", loads - l0, exp_err(t, se, sv) != 0 ? 0 : 2 * ROUNDS);
    repeat (40) @(negedge clk);
    eq("R8 counts held", int'(total_cnt) * 4096 + int'(in_cnt) * 64 + int'(out_cnt),
       tt * 4096 + ti * 64 + (tt - ti));
    eq("R8 done held", int'(done), 1);
  endtask

  initial begin
    int t, ni;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    eq("R1 shift_clk idle", int'(shift_clk), 1);
    eq("R1 in_load idle", int'(in_load), 0);
    eq("R1 out_latch", int'(out_latch), 1);
    eq("R1 ser_out", int'(ser_out), 0);
    eq("R1 done/error", int'(done) + int'(error), 0);
    eq("R1 counts", int'(total_cnt) + int'(in_cnt) + int'(out_cnt), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    eq("R1 idle after reset", int'(shift_clk) * 2 + int'(in_load), 2);
    eq("R1 out_latch after reset", int'(out_latch), 1);

    // directed corners
    run(0, 1, 32'h0, 1'b0, 1'b0, 1'b0);          // R6 boundary pin 0
    run(0, 1, 32'h1, 1'b0, 1'b0, 1'b0);          // R6 boundary pin 1
    run(3, 4, 32'hA, 1'b0, 1'b0, 1'b1);          // R8 start while busy
    run(3, 4, 32'h5, 1'b0, 1'b0, 1'b0);          // R6 other polarity
    run(31, 0, 32'h0, 1'b0, 1'b0, 1'b0);         // R4 longest, no inputs
    run(0, 31, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0); // R4 longest, all inputs
    run(16, 16, 32'h1234, 1'b0, 1'b0, 1'b0);     // R5 32 stages overflow
    run(2, 2, 32'h0, 1'b1, 1'b0, 1'b0);          // R5 line stuck low
    run(2, 2, 32'h0, 1'b1, 1'b1, 1'b0);          // R9 line stuck high
    for (int k = 0; k < 8; k++) begin
      t  = 1 + int'($urandom % 31);
      ni = int'($urandom % (t + 1));
      run(t - ni, ni, $urandom, 1'b0, 1'b0, 1'b0);
    end

    eq("R2 low phase length", bad_low, 0);
    eq("R3 strobe length", bad_ld, 0);
    eq("R10 serial-out settle", bad_settle, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule